// File: doc/BRIEF.md
# Auxiliary Register File with Accumulator

This block adds an accumulator register (called ACC here) and a bank of 31 addressable 16-bit scratch registers to a microprogrammed processor. The scratch registers take slots 1 to 31 of a 5-bit select space. Only a task that is marked as RAM-related can use the block. For any other task the block does nothing.

ACC captures the ALU result at the clock edge when the microinstruction's load-L bit is set. A bus-source store code copies the current ACC value, with no shift applied, into the scratch slot named by the register-select field. A bus-source read code drives the selected slot onto the processor bus. The processor bus is a wired-AND bus, so this block drives all ones whenever it has nothing to contribute. Reading select 0 returns ACC, because slot 0 has no storage behind it.

An operation decoder classifies each cycle into one of three named states:

- `OP_IDLE`: no bus access by this block.
- `OP_STORE`: scratch register write from ACC.
- `OP_READ`: scratch register or ACC drive onto the bus.

The classification changes every cycle, directly from the inputs:

- Any cycle with `ram_task` low is `OP_IDLE`.
- With `ram_task` high, `bs_store` leads to `OP_STORE` and takes priority over `bs_read`.
- With `ram_task` high and `bs_store` low, `bs_read` leads to `OP_READ`.
- Everything else is `OP_IDLE`.

The output process maps `OP_READ` to the selected data and both other states to all ones.

Top module: `aux_regfile`

## Requirements
- R1: After reset, ACC and all scratch slots 1 to 31 read as 0x0000, and the bus output is 0xFFFF while no read is requested.
- R2: With `ram_task` and `load_l` high, ACC takes `alu_res` at the clock edge. A read at select 0 in the next cycle returns that value.
- R3: ACC keeps its value in every cycle where `load_l` is low.
- R4: In `OP_STORE` with select 1 to 31, the selected slot takes the ACC value present before the edge, bit for bit. A read of that slot in a later cycle returns it.
- R5: In `OP_READ` with select 1 to 31, `bus_out` shows the selected slot's content in the same cycle, with no register delay.
- R6: In `OP_READ` with select 0, `bus_out` shows the current ACC value.
- R7: A store with select 0 changes no stored state, and the ACC value reads back unchanged afterwards.
- R8: While `ram_task` is low, load and store requests change no state and `bus_out` is 0xFFFF.
- R9: In `OP_IDLE` and `OP_STORE`, `bus_out` is 0xFFFF, so a store never drives the bus low. When `bs_store` and `bs_read` are both set, the store wins.
- R10: When ACC load and store happen in the same cycle, the slot receives the old ACC value and ACC receives `alu_res`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ram_task | input | 1 | High while the running task is RAM-related |
| load_l | input | 1 | Load-L bit of the microinstruction |
| alu_res | input | 16 | ALU result |
| rsel | input | 5 | Register-select field |
| bs_store | input | 1 | Bus-source decode: store ACC into a slot |
| bs_read | input | 1 | Bus-source decode: read a slot onto the bus |
| bus_out | output | 16 | Data for the AND-bus; all ones when not driving |

## Verification
The bus output is combinational from the decode and the stored registers. The bench therefore drives each vector one nanosecond after a falling edge and samples `bus_out` before the next rising edge, in the same cycle as the request. Loads and stores land at the rising edge that ends their cycle. Their effect is checked by a read vector placed in the following cycle or later, never in the same one. That ordering is what separates old-ACC from new-ACC in the load-plus-store case.

// File: rtl/aux_regfile_pkg.sv
package aux_regfile_pkg;

    localparam int DATA_W = 16;
    localparam int SEL_W  = 5;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_STORE = 2'd1,
        OP_READ  = 2'd2
    } aux_op_e;

endpackage

// File: rtl/aux_op_decode.sv
module aux_op_decode
    import aux_regfile_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    ram_task,
    input  logic    load_l,
    input  logic    bs_store,
    input  logic    bs_read,
    output aux_op_e op,
    output logic    acc_we
);

    always_comb begin
        op = OP_IDLE;
        if (ram_task) begin
            if (bs_store)     op = OP_STORE;
            else if (bs_read) op = OP_READ;
        end
    end

    assign acc_we = ram_task & load_l;

    // R8
    idle_when_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_task |-> (op == OP_IDLE && !acc_we));

    // R9
    store_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_task && bs_store && bs_read) |-> (op == OP_STORE));

endmodule

// File: rtl/aux_acc_reg.sv
module aux_acc_reg #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= din;
    end

    // R2
    acc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (q == $past(din)));

    // R3
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));

endmodule

// File: rtl/aux_slot_file.sv
module aux_slot_file #(
    parameter int DW   = 16,
    parameter int SELW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [SELW-1:0] sel,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata
);

    localparam int NSLOT = 1 << SELW;

    logic [DW-1:0] slot_q [NSLOT];

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        if (g == 0) begin : g_empty
            assign slot_q[g] = '0;
        end else begin : g_store
            always_ff @(posedge clk) begin
                if (!rst_n)
                    slot_q[g] <= '0;
                else if (we && sel == SELW'(g))
                    slot_q[g] <= wdata;
            end
        end
    end

    assign rdata = slot_q[sel];

    // R4
    slot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel != '0) |=> (slot_q[$past(sel)] == $past(wdata)));

    // R7
    slot_zero_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) |-> (rdata == '0));

endmodule

// File: rtl/aux_regfile.sv
module aux_regfile
    import aux_regfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ram_task,
    input  logic              load_l,
    input  logic [DATA_W-1:0] alu_res,
    input  logic [SEL_W-1:0]  rsel,
    input  logic              bs_store,
    input  logic              bs_read,
    output logic [DATA_W-1:0] bus_out
);

    aux_op_e           op;
    logic              acc_we;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] slot_rd;

    aux_op_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .ram_task (ram_task),
        .load_l   (load_l),
        .bs_store (bs_store),
        .bs_read  (bs_read),
        .op       (op),
        .acc_we   (acc_we)
    );

    aux_acc_reg #(.DW(DATA_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (acc_we),
        .din   (alu_res),
        .q     (acc_q)
    );

    aux_slot_file #(.DW(DATA_W), .SELW(SEL_W)) u_slots (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (op == OP_STORE),
        .sel   (rsel),
        .wdata (acc_q),
        .rdata (slot_rd)
    );

    always_comb begin
        unique case (op)
            OP_READ:  bus_out = (rsel == '0) ? acc_q : slot_rd;
            OP_STORE: bus_out = '1;
            default:  bus_out = '1;
        endcase
    end

    // R8
    bus_quiet_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_task |-> (bus_out == '1));

    // R6
    sel0_reads_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_task && bs_read && !bs_store && rsel == '0) |-> (bus_out == acc_q));

    // R9
    store_not_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bs_store |-> (bus_out == '1));

endmodule

// File: tb/aux_regfile_tb_top.sv
module aux_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ram_task, load_l, bs_store, bs_read;
    logic [15:0] alu_res;
    logic [4:0]  rsel;
    logic [15:0] bus_out;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    aux_regfile dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ram_task (ram_task),
        .load_l   (load_l),
        .alu_res  (alu_res),
        .rsel     (rsel),
        .bs_store (bs_store),
        .bs_read  (bs_read),
        .bus_out  (bus_out)
    );

    // Vector fields: req[4] task ld st rd sel[5] alu[16] exp[16] = 45 bits
    localparam int NV = 19;
    localparam logic [44:0] VEC [NV] = '{
        {4'd2,  1'b1,1'b1,1'b0,1'b1, 5'd0,  16'h1234, 16'h0000}, // R2 read old ACC, load
        {4'd2,  1'b1,1'b0,1'b0,1'b1, 5'd0,  16'h0000, 16'h1234}, // R2/R6
        {4'd4,  1'b1,1'b0,1'b1,1'b0, 5'd5,  16'h0000, 16'hFFFF}, // R4 store slot5
        {4'd10, 1'b1,1'b1,1'b1,1'b0, 5'd7,  16'hABCD, 16'hFFFF}, // R10 load+store
        {4'd10, 1'b1,1'b0,1'b0,1'b1, 5'd7,  16'h0000, 16'h1234}, // R10 slot gets old
        {4'd10, 1'b1,1'b0,1'b0,1'b1, 5'd0,  16'h0000, 16'hABCD}, // R10 ACC new
        {4'd4,  1'b1,1'b0,1'b1,1'b0, 5'd3,  16'h0000, 16'hFFFF}, // R4 store slot3
        {4'd5,  1'b1,1'b0,1'b0,1'b1, 5'd3,  16'h0000, 16'hABCD}, // R5
        {4'd8,  1'b0,1'b1,1'b0,1'b1, 5'd0,  16'h5555, 16'hFFFF}, // R8 inactive
        {4'd8,  1'b0,1'b0,1'b1,1'b0, 5'd3,  16'h0000, 16'hFFFF}, // R8
        {4'd8,  1'b1,1'b0,1'b0,1'b1, 5'd3,  16'h0000, 16'hABCD}, // R8 slot kept
        {4'd8,  1'b1,1'b0,1'b0,1'b1, 5'd0,  16'h0000, 16'hABCD}, // R8 ACC kept
        {4'd7,  1'b1,1'b0,1'b1,1'b0, 5'd0,  16'h0000, 16'hFFFF}, // R7 store sel0
        {4'd7,  1'b1,1'b0,1'b0,1'b1, 5'd0,  16'h0000, 16'hABCD}, // R7
        {4'd5,  1'b1,1'b0,1'b0,1'b1, 5'd31, 16'h0000, 16'h0000}, // R5 slot31
        {4'd9,  1'b1,1'b1,1'b0,1'b0, 5'd0,  16'h0F0F, 16'hFFFF}, // R9 idle
        {4'd3,  1'b1,1'b0,1'b0,1'b1, 5'd0,  16'h7777, 16'h0F0F}, // R3 no load
        {4'd9,  1'b1,1'b0,1'b1,1'b1, 5'd5,  16'h0000, 16'hFFFF}, // R9 store wins
        {4'd4,  1'b1,1'b0,1'b0,1'b1, 5'd5,  16'h0000, 16'h0F0F}  // R4 overwritten
    };

    task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL R%0d: bus_out=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic t, input logic ld, input logic st, input logic rd,
                         input logic [4:0] s, input logic [15:0] a);
        @(negedge clk);
        ram_task = t; load_l = ld; bs_store = st; bs_read = rd; rsel = s; alu_res = a;
        #1;
    endtask

    initial begin
        #200000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ram_task = 0; load_l = 0; bs_store = 0; bs_read = 0;
        rsel = '0; alu_res = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state: idle bus, then every location reads zero
        drive(1, 0, 0, 0, 5'd0, 16'h0);
        check(1, bus_out, 16'hFFFF);
        for (int s = 0; s < 32; s++) begin
            drive(1, 0, 0, 1, 5'(s), 16'h0);
            check(1, bus_out, 16'h0000);
        end

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][40], VEC[i][39], VEC[i][38], VEC[i][37],
                  VEC[i][36:32], VEC[i][31:16]);
            check(int'(VEC[i][44:41]), bus_out, VEC[i][15:0]);
        end

        // R4 bit-exact copy across all slots, patterns distinct per slot
        for (int s = 1; s < 32; s++) begin
            drive(1, 1, 0, 0, 5'd0, 16'(16'hA500 ^ (s * 16'h0111)));
            drive(1, 0, 1, 0, 5'(s), 16'h0);
        end
        for (int s = 1; s < 32; s++) begin
            drive(1, 0, 0, 1, 5'(s), 16'h0);
            check(4, bus_out, 16'(16'hA500 ^ (s * 16'h0111)));
        end

        // R1 reset mid-run clears state
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        drive(1, 0, 0, 1, 5'd9, 16'h0);
        check(1, bus_out, 16'h0000);
        drive(1, 0, 0, 1, 5'd0, 16'h0);
        check(1, bus_out, 16'h0000);

        // R8 inactive read of a filled slot still all ones
        drive(1, 1, 0, 0, 5'd0, 16'h00FF);
        drive(1, 0, 1, 0, 5'd2, 16'h0);
        drive(0, 0, 0, 1, 5'd2, 16'h0);
        check(8, bus_out, 16'hFFFF);
        drive(1, 0, 0, 1, 5'd2, 16'h0);
        check(5, bus_out, 16'h00FF);

        drive(1, 0, 0, 0, 5'd0, 16'h0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule